// File: doc/BRIEF.md
# PCI Legacy Interrupt Router with Mapping Detection

This block takes the four legacy interrupt pins (INTA to INTD) of every device on a small PCI backplane and routes them onto four level-sensitive host interrupt lines. Each device presents its slot number and its four pin levels. A variant select picks one of two board wirings. Both wirings rotate pins by slot, and they differ only in a fixed extra offset.

Some older host software expects an incorrect one-to-one pin mapping. A sticky three-state mode register watches configuration-space writes to detect such software. The register starts in an assume-correct state. The first write to a device's interrupt-line register that can tell the two mappings apart moves it, for good, to either a legacy state or a force-correct state. Only a reset leaves those states. Several pins that share a host line are merged with a logical OR.

Top module: `irq_router`

## Requirements
- R1: After reset the mode is assume-correct, so routing follows the correct mapping of the selected variant.
- R2: In assume-correct mode, on variant 0, a qualifying write carrying data value 27 switches routing to the legacy mapping. The new mapping shows from the cycle after the write, and routing is unchanged during the write cycle. A qualifying write has `cfg_wr_i` high, address bits [7:0] equal to 0x3C, and slot = address bits [15:11] with slot mod 4 not equal to 2.
- R3: In assume-correct mode, on variant 0, a qualifying write carrying any value other than 27 switches to force-correct, which routes exactly like the correct mapping.
- R4: Once in legacy or force-correct, no later configuration write changes the mode until reset.
- R5: Writes whose address bits [7:0] are not 0x3C leave the mode unchanged.
- R6: Writes to slots whose number mod 4 equals 2 leave the mode unchanged.
- R7: On variant 1 snooping is disabled, and pin p of a device in slot s drives output (s + p + 3) mod 4.
- R8: On variant 0 in correct (assume-correct or force-correct) mode, pin p of slot s drives output (s + p + 2) mod 4. Pin indices are INTA=0 to INTD=3.
- R9: In legacy mode on variant 0, pin p drives output p regardless of slot.
- R10: Each output is the OR of the levels of all device pins mapped to it. All outputs are low when no pin is asserted.
- R11: Address and data presented with `cfg_wr_i` low have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 1 | Board wiring select: 0 = first variant (snooping on), 1 = second variant |
| dev_slot_i | input | NUM_DEV*5 | Slot number of each device, device 0 in the low bits |
| dev_irq_i | input | NUM_DEV*4 | Pin levels per device, bit 4*d+p is pin p of device d |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration write address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| irq_o | output | 4 | Merged host interrupt lines |

## Verification
A wrong mode value shows at the ports in the first cycle after the write that caused it. The reason is that the legacy and correct mappings send a single pin to different lines for every slot whose number mod 4 is not 2. The bench therefore follows each snooped write with a full sweep of slots and pins, and with a check made during the write cycle itself, to catch a mode that changes too early or too late. A fault in the merge shows only when several pins are active at once, so the bench also drives every combination of the levels of four devices.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int PIN_CNT  = 4;
  localparam int LINE_CNT = 4;
  localparam int SLOT_W   = 5;

  typedef enum logic [1:0] {
    MAP_ASSUME = 2'd0,
    MAP_LEGACY = 2'd1,
    MAP_FIXED  = 2'd2
  } map_mode_e;
endpackage

// File: rtl/irq_map_mode.sv
module irq_map_mode
  import irq_router_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  LINE_OFS   = 8'h3C,
  parameter int unsigned LEGACY_VAL = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output map_mode_e         mode_o
);
  localparam logic [DATA_W-1:0] LegacyWord = DATA_W'(LEGACY_VAL);

  logic [SLOT_W-1:0] wr_slot;
  logic              hit_line;
  logic              slot_ok;
  logic              snoop;
  map_mode_e         mode_q, mode_d;

  assign wr_slot  = cfg_addr_i[15:11];
  assign hit_line = (cfg_addr_i[7:0] == LINE_OFS);
  // slots 2 mod 4 route identically under both mappings
  assign slot_ok  = (wr_slot[1:0] != 2'd2);
  assign snoop    = cfg_wr_i && !variant_i && hit_line && slot_ok;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MAP_ASSUME && snoop) begin
      mode_d = (cfg_wdata_i == LegacyWord) ? MAP_LEGACY : MAP_FIXED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MAP_ASSUME;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/irq_pin_route.sv
module irq_pin_route
  import irq_router_pkg::*;
#(
  parameter int unsigned ROT_BASE = 2,
  parameter int unsigned ROT_ALT  = 3
) (
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                variant_i,
  input  map_mode_e           mode_i,
  input  logic [PIN_CNT-1:0]  pins_i,
  output logic [LINE_CNT-1:0] hits_o
);
  logic       direct;
  logic [1:0] rot;

  assign direct = (mode_i == MAP_LEGACY) && !variant_i;
  assign rot    = variant_i ? 2'(ROT_ALT) : 2'(ROT_BASE);

  logic [1:0] idx [PIN_CNT];

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    assign idx[p] = direct ? 2'(p) : (slot_i[1:0] + 2'(p) + rot);
  end

  always_comb begin
    hits_o = '0;
    for (int p = 0; p < PIN_CNT; p++) begin
      if (pins_i[p]) hits_o[idx[p]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
  import irq_router_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV*LINE_CNT-1:0] hits_i,
  output logic [LINE_CNT-1:0]         lines_o
);
  always_comb begin
    lines_o = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      lines_o |= hits_i[d*LINE_CNT +: LINE_CNT];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_DEV    = 4,
  parameter int          ADDR_W     = 24,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  LINE_OFS   = 8'h3C,
  parameter int unsigned LEGACY_VAL = 27,
  parameter int unsigned ROT_BASE   = 2,
  parameter int unsigned ROT_ALT    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       variant_i,
  input  logic [NUM_DEV*SLOT_W-1:0]  dev_slot_i,
  input  logic [NUM_DEV*PIN_CNT-1:0] dev_irq_i,
  input  logic                       cfg_wr_i,
  input  logic [ADDR_W-1:0]          cfg_addr_i,
  input  logic [DATA_W-1:0]          cfg_wdata_i,
  output logic [LINE_CNT-1:0]        irq_o
);
  localparam int HitW = NUM_DEV * LINE_CNT;

  map_mode_e       mode_q;
  logic [HitW-1:0] hits;

  irq_map_mode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINE_OFS  (LINE_OFS),
    .LEGACY_VAL(LEGACY_VAL)
  ) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .variant_i  (variant_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .mode_o     (mode_q)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    irq_pin_route #(
      .ROT_BASE(ROT_BASE),
      .ROT_ALT (ROT_ALT)
    ) u_route (
      .slot_i   (dev_slot_i[d*SLOT_W +: SLOT_W]),
      .variant_i(variant_i),
      .mode_i   (mode_q),
      .pins_i   (dev_irq_i[d*PIN_CNT +: PIN_CNT]),
      .hits_o   (hits[d*LINE_CNT +: LINE_CNT])
    );
  end

  irq_line_merge #(
    .NUM_DEV(NUM_DEV)
  ) u_merge (
    .hits_i (hits),
    .lines_o(irq_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int          NUM_DEV    = 4,
  parameter int          ADDR_W     = 24,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  LINE_OFS   = 8'h3C,
  parameter int unsigned LEGACY_VAL = 27
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       variant_i,
  input logic [NUM_DEV*PIN_CNT-1:0] dev_irq_i,
  input logic                       cfg_wr_i,
  input logic [ADDR_W-1:0]          cfg_addr_i,
  input logic [DATA_W-1:0]          cfg_wdata_i,
  input logic [LINE_CNT-1:0]        irq_o,
  input map_mode_e                  mode_i
);
  logic qual;
  assign qual = cfg_wr_i && !variant_i && (cfg_addr_i[7:0] == LINE_OFS)
                && (cfg_addr_i[12:11] != 2'd2);

  p_legacy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && qual && cfg_wdata_i == DATA_W'(LEGACY_VAL)) |=> mode_i == MAP_LEGACY);

  p_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && qual && cfg_wdata_i != DATA_W'(LEGACY_VAL)) |=> mode_i == MAP_FIXED);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MAP_ASSUME) |=> $stable(mode_i));

  p_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && cfg_addr_i[7:0] != LINE_OFS) |=> mode_i == MAP_ASSUME);

  p_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && cfg_addr_i[12:11] == 2'd2) |=> mode_i == MAP_ASSUME);

  p_nosnoop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && variant_i) |=> mode_i == MAP_ASSUME);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_irq_i == '0) |-> (irq_o == '0));

  p_nowrite_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_ASSUME && !cfg_wr_i) |=> mode_i == MAP_ASSUME);
endmodule

bind irq_router irq_router_chk #(
  .NUM_DEV   (NUM_DEV),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LINE_OFS  (LINE_OFS),
  .LEGACY_VAL(LEGACY_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .variant_i  (variant_i),
  .dev_irq_i  (dev_irq_i),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .irq_o      (irq_o),
  .mode_i     (mode_q)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int NDEV = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        variant_i = 1'b0;
  logic [19:0] dev_slot_i = '0;
  logic [15:0] dev_irq_i = '0;
  logic        cfg_wr_i = 1'b0;
  logic [23:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [3:0]  irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i),
    .dev_slot_i(dev_slot_i), .dev_irq_i(dev_irq_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .irq_o(irq_o)
  );

  function automatic logic [23:0] cfg_addr(input int slot, input int ofs);
    return {8'h00, 5'(slot), 3'b000, 8'(ofs)};
  endfunction

  function automatic int line_of(input int slot, input int pin, input bit var1, input bit legacy);
    if (legacy && !var1) return pin;
    return (slot + pin + (var1 ? 3 : 2)) % 4;
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    n_run++;
    if (irq_o !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%b expected=%b (t=%0t)", tag, irq_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_wr_i = 1'b0;
    dev_irq_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg_write(input int slot, input int ofs, input int data);
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    cfg_addr_i = cfg_addr(slot, ofs);
    cfg_wdata_i = 32'(data);
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    #1;
  endtask

  // one device active, every slot and pin
  task automatic sweep(input bit legacy, input string tag);
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        dev_slot_i = {15'd0, 5'(s)};
        dev_irq_i = 16'(1 << p);
        #1;
        check(4'(1 << line_of(s, p, variant_i, legacy)), tag);
      end
    end
    dev_irq_i = '0;
    #1;
    check(4'b0000, tag);
  endtask

  // single probe: slot 31 INTA on device 0
  task automatic probe(input int exp_line, input string tag);
    dev_slot_i = {15'd0, 5'd31};
    dev_irq_i = 16'h0001;
    #1;
    check(4'(1 << exp_line), tag);
    dev_irq_i = '0;
    #1;
  endtask

  // every level combination on four devices in slots 31..28
  task automatic merge_all(input bit legacy, input string tag);
    dev_slot_i = {5'd28, 5'd29, 5'd30, 5'd31};
    for (int pat = 0; pat < 65536; pat++) begin
      logic [3:0] exp = '0;
      dev_irq_i = 16'(pat);
      for (int d = 0; d < NDEV; d++)
        for (int p = 0; p < 4; p++)
          if (pat[d*4+p]) exp[line_of(31 - d, p, variant_i, legacy)] = 1'b1;
      #1;
      check(exp, tag);
    end
    dev_irq_i = '0;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: expired actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 / R8: reset state is correct mapping, rotation 2
    #1;
    check(4'b0000, "R1 idle after reset");
    sweep(1'b0, "R1 R8 variant0 correct");
    merge_all(1'b0, "R10 merge variant0 correct");

    // R7: variant 1 mapping and no snooping
    variant_i = 1'b1;
    sweep(1'b0, "R7 variant1 mapping");
    cfg_write(31, 8'h3C, 27);
    probe(2, "R7 no snoop on variant1");
    merge_all(1'b0, "R10 merge variant1");
    variant_i = 1'b0;
    probe(1, "R7 still assume on return to variant0");

    // R5: wrong offset
    cfg_write(31, 8'h3D, 27);
    probe(1, "R5 offset 0x3D ignored");
    cfg_write(31, 8'h00, 5);
    probe(1, "R5 offset 0x00 ignored");

    // R11: no strobe
    @(negedge clk_i);
    cfg_addr_i = cfg_addr(31, 8'h3C);
    cfg_wdata_i = 32'd27;
    @(negedge clk_i);
    @(negedge clk_i);
    #1;
    probe(1, "R11 no strobe ignored");

    // R6: slots 2 mod 4
    cfg_write(30, 8'h3C, 27);
    probe(1, "R6 slot 30 ignored");
    cfg_write(2, 8'h3C, 9);
    probe(1, "R6 slot 2 ignored");

    // R2: legacy, effective the cycle after the write
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    cfg_addr_i = cfg_addr(31, 8'h3C);
    cfg_wdata_i = 32'd27;
    dev_slot_i = {15'd0, 5'd31};
    dev_irq_i = 16'h0001;
    #1;
    check(4'b0010, "R2 unchanged during write cycle");
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    #1;
    check(4'b0001, "R2 legacy on next cycle");
    dev_irq_i = '0;
    sweep(1'b1, "R9 legacy sweep");
    merge_all(1'b1, "R10 merge legacy");

    // R4: sticky legacy
    cfg_write(29, 8'h3C, 11);
    probe(0, "R4 legacy sticky");
    // R7: variant 1 ignores legacy mode
    variant_i = 1'b1;
    probe(2, "R7 variant1 correct in legacy mode");
    variant_i = 1'b0;

    // R3: force-correct
    do_reset();
    probe(1, "R1 assume after reset");
    cfg_write(29, 8'h3C, 11);
    probe(1, "R3 force-correct");
    sweep(1'b0, "R3 force-correct sweep");
    cfg_write(31, 8'h3C, 27);
    probe(1, "R4 force-correct sticky");
    cfg_write(28, 8'h3C, 27);
    probe(1, "R4 force-correct sticky slot 28");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule